// File: doc/BRIEF.md
# Branch Condition Evaluator

This block keeps three status flags taken from the arithmetic unit: negative, zero and carry-out. It then decides whether a branch instruction should be taken. A flag register is updated only on cycles where the arithmetic unit marks its result as valid. The flags are held in between, and reset clears them.

When an instruction word is presented, the block decodes the operation code and the three-bit condition field. It picks one of eight conditions and drives a single taken signal. The decision path is purely combinational, so the answer is ready in the same cycle the instruction is presented. Target address arithmetic and program counter updates are done elsewhere.

The condition codes come in complementary pairs: flipping the top bit of a code inverts the test. The one exception is the pair at 000 and 100, which holds "always" and "carry clear".

Top module: `branch_cond_eval`

## Requirements
- R1: Reset (rst high) clears the negative, zero and carry flags. After reset, condition 100 is taken, and conditions 001 and 010 are not taken.
- R2: The flags change only on a rising clock edge where aluValid is high. At any other edge they keep their values, whatever aluResult and aluCarry carry.
- R3: The negative flag captures bit DATA_W-1 of aluResult.
- R4: The zero flag is set when every bit of aluResult is 0.
- R5: The carry flag captures aluCarry.
- R6: Condition code 000 is always taken.
- R7: Code 001 is taken when the negative flag is 1. Code 101 is taken when the negative flag is 0.
- R8: Code 010 is taken when the zero flag is 1. Code 110 is taken when the zero flag is 0.
- R9: Code 011 (not positive) is taken when the negative flag or the zero flag is 1. Code 111 (positive) is taken when both flags are 0.
- R10: Code 100 is taken when the carry flag is 0.
- R11: The operation code sits in instruction bits 31..27 and the condition code in bits 25..23. branchTaken is 0 unless the operation code equals 01111. All other instruction bits have no effect.
- R12: branchTaken is a combinational function of instrWord and the stored flags. Flags captured at an edge take effect on the output right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aluValid | input | 1 | Arithmetic result valid strobe |
| aluResult | input | 32 | Arithmetic result word |
| aluCarry | input | 1 | Carry-out of the arithmetic unit |
| instrWord | input | 32 | Current instruction word |
| branchTaken | output | 1 | High when the branch is taken |

## Verification
Each condition code is tried against flag sets that make it true and against flag sets that make it false. This shows that each code reads the correct flag and has the correct polarity.

Results with only the sign bit set, all bits set, exactly zero, and small positive values separate the negative test from the zero test. They also separate the not-positive code from the positive code, and the carry test from the sign test.

Strobe-low cycles carrying hostile data show that flags are held between valid results. Non-branch operation codes, and words with noise in the unused fields, show that decoding looks only at the two fields it should.

// File: rtl/bce_pkg.sv
package bce_pkg;
  localparam int DATA_W     = 32;
  localparam int INSTR_W    = 32;
  localparam int OPC_W      = 5;
  localparam int OPC_LSB    = 27;
  localparam int COND_W     = 3;
  localparam int COND_LSB   = 23;
  localparam int COND_NUM   = 1 << COND_W;
  localparam int HALF_NUM   = COND_NUM / 2;
  localparam logic [OPC_W-1:0] BRANCH_OPC = 5'b01111;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
  } flags_t;

  typedef struct packed {
    logic captureFlags;
  } strobes_t;
endpackage

// File: rtl/bce_flag_path.sv
module bce_flag_path
  import bce_pkg::*;
#(
  parameter int RES_W = DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  strobes_t         strobes,
  input  logic [RES_W-1:0] aluResult,
  input  logic             aluCarry,
  output flags_t           flags
);
  localparam int SIGN_BIT = RES_W - 1;

  flags_t flagsNext;

  always_comb begin
    flagsNext.neg   = aluResult[SIGN_BIT];
    flagsNext.zero  = (aluResult == '0);
    flagsNext.carry = aluCarry;
  end

  always_ff @(posedge clk) begin
    if (rst)                       flags <= '0;
    else if (strobes.captureFlags) flags <= flagsNext;
  end

  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !strobes.captureFlags |=> $stable(flags));
  a_r3_neg_from_sign: assert property (@(posedge clk) disable iff (rst)
    strobes.captureFlags |=> flags.neg == $past(aluResult[SIGN_BIT]));
  a_r4_zero_detect: assert property (@(posedge clk) disable iff (rst)
    strobes.captureFlags |=> flags.zero == ($past(aluResult) == '0));
  a_r5_carry_capture: assert property (@(posedge clk) disable iff (rst)
    strobes.captureFlags |=> flags.carry == $past(aluCarry));
endmodule

// File: rtl/bce_control.sv
module bce_control
  import bce_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              aluValid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [COND_W-1:0] condCode,
  input  flags_t            flags,
  output strobes_t          strobes,
  output logic              branchTaken
);
  logic [COND_NUM-1:0] condVec;
  logic                isBranch;

  always_comb strobes.captureFlags = aluValid;

  // Lower half: base tests; upper half mirrors them inverted, except slot 0.
  assign condVec[0]        = 1'b1;
  assign condVec[HALF_NUM] = ~flags.carry;
  assign condVec[1]        = flags.neg;
  assign condVec[2]        = flags.zero;
  assign condVec[3]        = flags.neg | flags.zero;

  for (genvar i = 1; i < HALF_NUM; i++) begin : g_opposite
    assign condVec[i + HALF_NUM] = ~condVec[i];
  end

  assign isBranch    = (opcode == BRANCH_OPC);
  assign branchTaken = isBranch & condVec[condCode];

  a_r6_always_taken: assert property (@(posedge clk) disable iff (rst)
    (isBranch && condCode == '0) |-> branchTaken);
  a_r10_carry_clear: assert property (@(posedge clk) disable iff (rst)
    (isBranch && condCode == COND_W'(HALF_NUM)) |-> (branchTaken == !flags.carry));
  a_r9_positive_pair: assert property (@(posedge clk) disable iff (rst)
    (isBranch && condCode == 3'b111) |-> (branchTaken == (!flags.neg && !flags.zero)));
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               aluValid,
  input  logic [DATA_W-1:0]  aluResult,
  input  logic               aluCarry,
  input  logic [INSTR_W-1:0] instrWord,
  output logic               branchTaken
);
  strobes_t strobes;
  flags_t   flags;

  bce_flag_path #(.RES_W(DATA_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .aluResult(aluResult),
    .aluCarry (aluCarry),
    .flags    (flags)
  );

  bce_control u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .aluValid   (aluValid),
    .opcode     (instrWord[OPC_LSB +: OPC_W]),
    .condCode   (instrWord[COND_LSB +: COND_W]),
    .flags      (flags),
    .strobes    (strobes),
    .branchTaken(branchTaken)
  );

  a_r11_non_branch_low: assert property (@(posedge clk) disable iff (rst)
    (instrWord[OPC_LSB +: OPC_W] != BRANCH_OPC) |-> !branchTaken);
endmodule

// File: tb/branch_cond_eval_test.sv
module branch_cond_eval_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        aluValid;
  logic [31:0] aluResult;
  logic        aluCarry;
  logic [31:0] instrWord;
  logic        branchTaken;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  branch_cond_eval uut (
    .clk(clk), .rst(rst), .aluValid(aluValid), .aluResult(aluResult),
    .aluCarry(aluCarry), .instrWord(instrWord), .branchTaken(branchTaken)
  );

  // {result, carry, cond, expected}
  localparam int NVEC = 14;
  localparam logic [36:0] VEC [NVEC] = '{
    {32'h0000_0005, 1'b0, 3'b000, 1'b1},
    {32'h8000_0000, 1'b0, 3'b001, 1'b1},
    {32'h8000_0000, 1'b0, 3'b101, 1'b0},
    {32'h0000_0000, 1'b1, 3'b010, 1'b1},
    {32'h0000_0000, 1'b1, 3'b110, 1'b0},
    {32'h0000_0000, 1'b1, 3'b011, 1'b1},
    {32'h0000_0007, 1'b0, 3'b111, 1'b1},
    {32'h0000_0007, 1'b0, 3'b011, 1'b0},
    {32'hFFFF_FFFF, 1'b1, 3'b100, 1'b0},
    {32'hFFFF_FFFF, 1'b0, 3'b100, 1'b1},
    {32'h7FFF_FFFF, 1'b0, 3'b101, 1'b1},
    {32'h0000_0001, 1'b0, 3'b110, 1'b1},
    {32'h8000_0000, 1'b0, 3'b111, 1'b0},
    {32'h8000_0000, 1'b0, 3'b011, 1'b1}
  };

  function automatic logic [31:0] mkInstr(logic [4:0] opc, logic [2:0] cond);
    return {opc, 1'b1, cond, 3'b101, 20'hA5C3E};
  endfunction

  task automatic check(string req, logic exp);
    nChecks++;
    if (branchTaken !== exp) begin
      nFails++;
      $display("FAIL %s: branchTaken=%b expected=%b (instr=%h)", req, branchTaken, exp, instrWord);
    end
  endtask

  task automatic loadAlu(logic [31:0] res, logic c);
    @(negedge clk);
    aluValid = 1'b1; aluResult = res; aluCarry = c;
    @(negedge clk);
    aluValid = 1'b0; aluResult = ~res; aluCarry = ~c;
  endtask

  task automatic probe(string req, logic [4:0] opc, logic [2:0] cond, logic exp);
    instrWord = mkInstr(opc, cond);
    #1;
    check(req, exp);
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rst = 1'b1; aluValid = 1'b0; aluResult = '0; aluCarry = 1'b0;
    instrWord = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    probe("R1", 5'b01111, 3'b100, 1'b1);
    probe("R1", 5'b01111, 3'b001, 1'b0);
    probe("R1", 5'b01111, 3'b010, 1'b0);
    probe("R1", 5'b01111, 3'b111, 1'b1);

    // Table walk: R3 R4 R5 R6 R7 R8 R9 R10 R12
    for (int i = 0; i < NVEC; i++) begin
      loadAlu(VEC[i][36:5], VEC[i][4]);
      probe("R3/R4/R5/R6..R10/R12 vector", 5'b01111, VEC[i][3:1], VEC[i][0]);
    end

    // R2: strobe low with hostile data keeps flags (Z=1, N=0, C=0)
    loadAlu(32'h0000_0000, 1'b0);
    @(negedge clk);
    aluResult = 32'h8000_0000; aluCarry = 1'b1;
    repeat (4) @(negedge clk);
    probe("R2", 5'b01111, 3'b010, 1'b1);
    probe("R2", 5'b01111, 3'b001, 1'b0);
    probe("R2", 5'b01111, 3'b100, 1'b1);

    // R11: non-branch opcodes never taken
    probe("R11", 5'b01110, 3'b000, 1'b0);
    probe("R11", 5'b00000, 3'b010, 1'b0);
    probe("R11", 5'b11111, 3'b000, 1'b0);
    instrWord = {5'b01111, 1'b0, 3'b010, 23'h7FFFFF};
    #1; check("R11", 1'b1);

    // R1: reset after flags set clears them
    loadAlu(32'h8000_0000, 1'b1);
    probe("R1 pre", 5'b01111, 3'b001, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    probe("R1", 5'b01111, 3'b001, 1'b0);
    probe("R1", 5'b01111, 3'b100, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule